// File: doc/BRIEF.md
# Keypad Matrix Scanner with Interrupt Status

The block scans a button matrix of up to 32 by 32 keys. Its default size is 8 by 8. A small register port gives software access to a control word, an interrupt status word, the last detected key position, the scan dwell period and two identification words. When scanning is turned on, the block pulls one row line low at a time. It reads the active-low column lines back through a two-flop synchronizer and picks the first pressed key in row-major order. A key is accepted only after two consecutive full scans agree on it.

An accepted key is recorded when the keypad function is enabled. Its column and row are stored as inverted one-hot words, and a keypad status bit is set. Two further status bits belong to an external serial keyboard path. Pulses on dedicated inputs set them. The interrupt line is a level output. It is high while any status bit is set together with its own enable. Status bits are cleared through trigger bits inside the control word. Those triggers act only when the same write also sets the chip-enable bit, and they read back as zero afterwards.

Top module: `kpad_ctrl`

## Requirements
- R1: After reset the block is in this state. Control, status and scan period read 0. The X word (offset 0x30) and Y word (offset 0x34) read 0xFFFFFFFF. `irq_o` is low.
- R2: Offset 0x50 reads 0x00010403. Offset 0x54 reads the row count in bits 15:8 and the column count in bits 7:0, which is 0x00000808 by default. Any other offset outside the register set reads 0. Writes to offsets other than 0x00 and 0x38 change nothing.
- R3: The control word at offset 0x00 stores bits 10:0, and bits above 10 read 0. If a write has bit 2 (chip enable) at 1, bits 6, 7 and 10 read back 0. If bit 2 is 0, the value is stored exactly as written.
- R4: A control write with bit 2 set clears status bits as follows. Bit 10 clears status bit 2 (keypad). Bit 7 clears status bit 0 (Rx). Bit 6 clears status bit 1 (Tx). The same trigger bits with bit 2 clear leave the status unchanged.
- R5: `irq_o` is the OR of three terms: status bit 2 AND control bit 8, status bit 1 AND control bit 3, and status bit 0 AND control bit 4.
- R6: A pulse on `tx_evt_i` sets status bit 1, and a pulse on `rx_evt_i` sets status bit 0. These bits are set whatever the enables are. A set wins over a clear in the same cycle.
- R7: An accepted key at row r, column c with control bit 8 set has three effects. X becomes ~(1<<c), Y becomes ~(1<<r), and status bit 2 is set. Releasing a key raises no status bit.
- R8: While control bit 9 is set, row lines go low one at a time, in ascending order. Each row stays low for max(P,4) cycles, where P is the scan period at offset 0x38 (bits 15:0 writable). While bit 9 is clear, all row lines are high.
- R9: When several keys are pressed, the reported key is the one with the lowest row, and within that row the lowest column.
- R10: A key is accepted only after two consecutive full scans have found it as their first pressed key. A key that stays held is reported once. It can be reported again only after a scan in which it was not found.
- R11: With control bit 8 clear, an accepted key changes neither X, Y nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| tx_evt_i | input | 1 | Transmit event pulse from serial path |
| rx_evt_i | input | 1 | Receive event pulse from serial path |
| row_drv_no | output | ROWS | Row drive lines, active low |
| col_sense_ni | input | COLS | Column sense lines, active low, asynchronous |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default sizes: an 8 by 8 matrix, a 16-bit period field and a minimum dwell of 4 cycles. This puts every row and every column within reach, including the corner keys at index 0 and index 7. It also places the 32-cycle minimum scan next to longer periods. Short periods (0 to 7) keep each full scan within a few dozen cycles. This lets randomly placed multi-key presses, the short-glitch debounce case and the dwell clamp all fit many times into one run.

// File: rtl/kpad_pkg.sv
`timescale 1ns/1ps
package kpad_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_STAT  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_XPOS  = 8'h30;
  localparam logic [REG_AW-1:0] OFS_YPOS  = 8'h34;
  localparam logic [REG_AW-1:0] OFS_SCANP = 8'h38;
  localparam logic [REG_AW-1:0] OFS_REV   = 8'h50;
  localparam logic [REG_AW-1:0] OFS_FEAT  = 8'h54;

  localparam int CTRL_W    = 11;
  localparam int CB_CLKDIS = 0;
  localparam int CB_DATDIS = 1;
  localparam int CB_CHIPEN = 2;
  localparam int CB_TXIE   = 3;
  localparam int CB_RXIE   = 4;
  localparam int CB_NOLC   = 5;
  localparam int CB_TXCLR  = 6;
  localparam int CB_RXCLR  = 7;
  localparam int CB_KPEN   = 8;
  localparam int CB_KPSCAN = 9;
  localparam int CB_KPCLR  = 10;

  localparam int STAT_W = 3;
  localparam int SB_RX  = 0;
  localparam int SB_TX  = 1;
  localparam int SB_KP  = 2;

  localparam logic [31:0] REV_VALUE = 32'h0001_0403;
endpackage

// File: rtl/kpad_sync.sv
`timescale 1ns/1ps
module kpad_sync #(
  parameter int          W       = 8,
  parameter logic        RST_BIT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= {W{RST_BIT}};
      s2_q <= {W{RST_BIT}};
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/kpad_scan.sv
`timescale 1ns/1ps
module kpad_scan #(
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int PERIOD_W  = 16,
  parameter int MIN_DWELL = 4,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scan_en_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [COLS-1:0]     col_ni,
  output logic [ROWS-1:0]     row_no,
  output logic                press_o,
  output logic [RW-1:0]       press_row_o,
  output logic [CW-1:0]       press_col_o
);
  localparam logic [PERIOD_W-1:0] MIN_LAST = PERIOD_W'(MIN_DWELL - 1);

  logic [RW-1:0]       row_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic                found_q, prev_v_q, held_q;
  logic [RW-1:0]       frow_q, prow_q;
  logic [CW-1:0]       fcol_q, pcol_q;

  logic [COLS-1:0]     pressed;
  logic                hit;
  logic [CW-1:0]       hit_col;
  logic [PERIOD_W-1:0] dwell_last;
  logic                sample, last_row;
  logic                cur_v, stable;
  logic [RW-1:0]       cur_row;
  logic [CW-1:0]       cur_col;

  assign pressed = ~col_ni;
  assign hit     = |pressed;

  // lowest pressed column wins
  always_comb begin
    hit_col = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (pressed[c]) hit_col = CW'(c);
    end
  end

  assign dwell_last = (period_i < PERIOD_W'(MIN_DWELL)) ? MIN_LAST
                                                       : period_i - PERIOD_W'(1);
  assign sample   = scan_en_i && (cnt_q >= dwell_last);
  assign last_row = (row_q == RW'(ROWS - 1));

  assign cur_v   = found_q | hit;
  assign cur_row = found_q ? frow_q : row_q;
  assign cur_col = found_q ? fcol_q : hit_col;
  assign stable  = cur_v && prev_v_q && (cur_row == prow_q) && (cur_col == pcol_q);

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_no[r] = !(scan_en_i && (row_q == RW'(r)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q       <= '0;
      cnt_q       <= '0;
      found_q     <= 1'b0;
      frow_q      <= '0;
      fcol_q      <= '0;
      prev_v_q    <= 1'b0;
      prow_q      <= '0;
      pcol_q      <= '0;
      held_q      <= 1'b0;
      press_o     <= 1'b0;
      press_row_o <= '0;
      press_col_o <= '0;
    end else begin
      press_o <= 1'b0;
      if (!scan_en_i) begin
        row_q    <= '0;
        cnt_q    <= '0;
        found_q  <= 1'b0;
        prev_v_q <= 1'b0;
        held_q   <= 1'b0;
      end else if (sample) begin
        cnt_q <= '0;
        if (last_row) begin
          row_q       <= '0;
          found_q     <= 1'b0;
          prev_v_q    <= cur_v;
          prow_q      <= cur_row;
          pcol_q      <= cur_col;
          held_q      <= stable;
          press_o     <= stable && !held_q;
          press_row_o <= cur_row;
          press_col_o <= cur_col;
        end else begin
          row_q <= row_q + RW'(1);
          if (!found_q && hit) begin
            found_q <= 1'b1;
            frow_q  <= row_q;
            fcol_q  <= hit_col;
          end
        end
      end else begin
        cnt_q <= cnt_q + PERIOD_W'(1);
      end
    end
  end

  a_r8_single_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~row_no) <= 1);

  a_r8_row_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && !sample) |=> (!scan_en_i || $stable(row_q)));

  a_r10_single_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o);
endmodule

// File: rtl/kpad_regs.sv
`timescale 1ns/1ps
module kpad_regs
  import kpad_pkg::*;
#(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int PERIOD_W = 16,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                tx_evt_i,
  input  logic                rx_evt_i,
  input  logic                press_i,
  input  logic [RW-1:0]       press_row_i,
  input  logic [CW-1:0]       press_col_i,
  output logic                scan_en_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                irq_o
);
  localparam logic [31:0] FEAT_VALUE = {16'h0, 8'(ROWS), 8'(COLS)};

  logic [CTRL_W-1:0]   ctrl_q, ctrl_wv;
  logic [STAT_W-1:0]   stat_q, stat_d;
  logic [31:0]         xpos_q, ypos_q;
  logic [PERIOD_W-1:0] per_q;
  logic                ctrl_wr, clr_act, kp_take;

  assign ctrl_wr = wr_i && (addr_i == OFS_CTRL);
  assign clr_act = ctrl_wr && wdata_i[CB_CHIPEN];
  assign kp_take = press_i && ctrl_q[CB_KPEN];

  // trigger bits self-clear only when chip enable is written as 1
  always_comb begin
    ctrl_wv = wdata_i[CTRL_W-1:0];
    if (wdata_i[CB_CHIPEN]) begin
      ctrl_wv[CB_KPCLR] = 1'b0;
      ctrl_wv[CB_RXCLR] = 1'b0;
      ctrl_wv[CB_TXCLR] = 1'b0;
    end
  end

  always_comb begin
    stat_d = stat_q;
    if (clr_act) begin
      if (wdata_i[CB_KPCLR]) stat_d[SB_KP] = 1'b0;
      if (wdata_i[CB_RXCLR]) stat_d[SB_RX] = 1'b0;
      if (wdata_i[CB_TXCLR]) stat_d[SB_TX] = 1'b0;
    end
    if (kp_take)  stat_d[SB_KP] = 1'b1;
    if (tx_evt_i) stat_d[SB_TX] = 1'b1;
    if (rx_evt_i) stat_d[SB_RX] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
      xpos_q <= '1;
      ypos_q <= '1;
      per_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (ctrl_wr) ctrl_q <= ctrl_wv;
      if (wr_i && (addr_i == OFS_SCANP)) per_q <= wdata_i[PERIOD_W-1:0];
      if (kp_take) begin
        xpos_q <= ~(32'd1 << press_col_i);
        ypos_q <= ~(32'd1 << press_row_i);
      end
    end
  end

  always_comb begin
    case (addr_i)
      OFS_CTRL:  rdata_o = 32'(ctrl_q);
      OFS_STAT:  rdata_o = 32'(stat_q);
      OFS_XPOS:  rdata_o = xpos_q;
      OFS_YPOS:  rdata_o = ypos_q;
      OFS_SCANP: rdata_o = 32'(per_q);
      OFS_REV:   rdata_o = REV_VALUE;
      OFS_FEAT:  rdata_o = FEAT_VALUE;
      default:   rdata_o = '0;
    endcase
  end

  assign scan_en_o = ctrl_q[CB_KPSCAN];
  assign period_o  = per_q;
  assign irq_o     = |(stat_q & {ctrl_q[CB_KPEN], ctrl_q[CB_TXIE], ctrl_q[CB_RXIE]});

  a_r3_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_act |=> !(ctrl_q[CB_KPCLR] || ctrl_q[CB_RXCLR] || ctrl_q[CB_TXCLR]));

  a_r4_kp_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_act && wdata_i[CB_KPCLR] && !kp_take) |=> !stat_q[SB_KP]);

  a_r5_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q == '0) |-> !irq_o);

  a_r7_press_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kp_take |=> stat_q[SB_KP]);

  a_r11_kp_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_i && !ctrl_q[CB_KPEN]) |=> ($stable(xpos_q) && $stable(ypos_q)));
endmodule

// File: rtl/kpad_ctrl.sv
`timescale 1ns/1ps
module kpad_ctrl
  import kpad_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int PERIOD_W  = 16,
  parameter int MIN_DWELL = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              tx_evt_i,
  input  logic              rx_evt_i,
  output logic [ROWS-1:0]   row_drv_no,
  input  logic [COLS-1:0]   col_sense_ni,
  output logic              irq_o
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic [COLS-1:0]     col_sync;
  logic                scan_en, press;
  logic [PERIOD_W-1:0] period;
  logic [RW-1:0]       press_row;
  logic [CW-1:0]       press_col;

  kpad_sync #(.W(COLS), .RST_BIT(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (col_sense_ni),
    .q_o   (col_sync)
  );

  kpad_scan #(
    .ROWS(ROWS), .COLS(COLS), .PERIOD_W(PERIOD_W), .MIN_DWELL(MIN_DWELL)
  ) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scan_en_i  (scan_en),
    .period_i   (period),
    .col_ni     (col_sync),
    .row_no     (row_drv_no),
    .press_o    (press),
    .press_row_o(press_row),
    .press_col_o(press_col)
  );

  kpad_regs #(.ROWS(ROWS), .COLS(COLS), .PERIOD_W(PERIOD_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .tx_evt_i   (tx_evt_i),
    .rx_evt_i   (rx_evt_i),
    .press_i    (press),
    .press_row_i(press_row),
    .press_col_i(press_col),
    .scan_en_o  (scan_en),
    .period_o   (period),
    .irq_o      (irq_o)
  );
endmodule

// File: tb/kpad_ctrl_tb.sv
`timescale 1ns/1ps
module kpad_ctrl_tb;
  localparam int NR = 8;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_evt = 1'b0, rx_evt = 1'b0;
  logic [NR-1:0] row_n;
  logic [NC-1:0] col_n;
  logic        irq;
  logic [NR*NC-1:0] keys = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  // matrix model: a pressed key shorts its column to its row
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < NR; r++)
        if (keys[r*NC+c] && !row_n[r]) col_n[c] = 1'b0;
    end
  end

  kpad_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_evt_i(tx_evt),
    .rx_evt_i(rx_evt), .row_drv_no(row_n), .col_sense_ni(col_n), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    chk(tag, v, exp);
  endtask

  function automatic int dwell_of(input int p);
    return (p < 4) ? 4 : p;
  endfunction

  function automatic int first_key(input logic [NR*NC-1:0] k);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        if (k[r*NC+c]) return r*NC + c;
    return -1;
  endfunction

  task automatic measure_dwell(input string tag, input int exp);
    int n = 0;
    while (row_n == 8'hFD) @(negedge clk);
    while (row_n != 8'hFD) @(negedge clk);
    while (row_n == 8'hFD) begin n++; @(negedge clk); end
    chk({tag, " dwell"}, 32'(n), 32'(exp));
    chk({tag, " next row"}, 32'(row_n), 32'hFB);
  endtask

  localparam logic [31:0] C_RUN = 32'h304; // chip en, keypad en, auto-scan

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] xv;
    void'($urandom(32'd20250611));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    rd_chk("R1 ctrl", 8'h00, 32'h0);
    rd_chk("R1 stat", 8'h10, 32'h0);
    rd_chk("R1 xpos", 8'h30, 32'hFFFF_FFFF);
    rd_chk("R1 ypos", 8'h34, 32'hFFFF_FFFF);
    rd_chk("R1 scanp", 8'h38, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 identification, unmapped, read-only
    rd_chk("R2 rev", 8'h50, 32'h0001_0403);
    rd_chk("R2 feat", 8'h54, 32'h0000_0808);
    wr_reg(8'h20, 32'hDEAD_BEEF);
    rd_chk("R2 unmapped", 8'h20, 32'h0);
    wr_reg(8'h30, 32'h0);
    rd_chk("R2 xpos ro", 8'h30, 32'hFFFF_FFFF);
    wr_reg(8'h50, 32'h0);
    rd_chk("R2 rev ro", 8'h50, 32'h0001_0403);
    wr_reg(8'h10, 32'h7);
    rd_chk("R2 stat ro", 8'h10, 32'h0);

    // R3 control storage
    wr_reg(8'h00, 32'h0000_05FB);
    rd_chk("R3 no chip en keeps triggers", 8'h00, 32'h5FB);
    wr_reg(8'h00, 32'hFFFF_F9FF);
    rd_chk("R3 chip en self clear", 8'h00, 32'h13F);
    wr_reg(8'h00, 32'h0);
    chk("R8 rows idle", 32'(row_n), 32'hFF);

    // R6 / R5 / R4 serial status bits
    @(negedge clk); tx_evt = 1'b1; @(negedge clk); tx_evt = 1'b0;
    rd_chk("R6 tx set", 8'h10, 32'h2);
    chk("R5 tx masked", 32'(irq), 32'h0);
    wr_reg(8'h00, 32'h8);
    chk("R5 tx enabled", 32'(irq), 32'h1);
    wr_reg(8'h00, 32'h10);
    chk("R5 rx enable only", 32'(irq), 32'h0);
    @(negedge clk); rx_evt = 1'b1; @(negedge clk); rx_evt = 1'b0;
    rd_chk("R6 rx set", 8'h10, 32'h3);
    chk("R5 rx irq", 32'(irq), 32'h1);
    wr_reg(8'h00, 32'h90);
    rd_chk("R4 clear without chip en", 8'h10, 32'h3);
    wr_reg(8'h00, 32'h94);
    rd_chk("R4 rx clear", 8'h10, 32'h2);
    chk("R5 irq after clear", 32'(irq), 32'h0);
    rd_chk("R3 readback", 8'h00, 32'h14);
    @(negedge clk); wr = 1'b1; addr = 8'h00; wdata = 32'h44; tx_evt = 1'b1;
    @(negedge clk); wr = 1'b0; tx_evt = 1'b0;
    rd_chk("R6 set beats clear", 8'h10, 32'h2);
    wr_reg(8'h00, 32'h44);
    rd_chk("R4 tx clear", 8'h10, 32'h0);

    // R8 scan timing
    wr_reg(8'h38, 32'h5);
    rd_chk("R8 scanp", 8'h38, 32'h5);
    wr_reg(8'h00, C_RUN);
    measure_dwell("R8 p5", 5);
    wr_reg(8'h38, 32'h2);
    measure_dwell("R8 p2 clamp", 4);
    wr_reg(8'h38, 32'h9);
    measure_dwell("R8 p9", 9);
    wr_reg(8'h38, 32'h5);

    // R7 single press, release
    keys[3*NC+5] = 1'b1;
    cyc(200);
    rd_chk("R7 xpos", 8'h30, ~(32'd1 << 5));
    rd_chk("R7 ypos", 8'h34, ~(32'd1 << 3));
    rd_chk("R7 stat", 8'h10, 32'h4);
    chk("R5 kp irq", 32'(irq), 32'h1);
    wr_reg(8'h00, C_RUN | 32'h400);
    rd_chk("R4 kp clear", 8'h10, 32'h0);
    cyc(200);
    rd_chk("R10 held once", 8'h10, 32'h0);
    keys = '0;
    cyc(200);
    rd_chk("R7 release silent", 8'h10, 32'h0);
    keys[3*NC+5] = 1'b1;
    cyc(200);
    rd_chk("R10 re-press", 8'h10, 32'h4);
    keys = '0;
    cyc(150);
    wr_reg(8'h00, C_RUN | 32'h400);

    // R10 short glitch: 12 cycles against a 32-cycle scan
    wr_reg(8'h38, 32'h4);
    cyc(40);
    keys[0*NC+0] = 1'b1;
    cyc(12);
    keys = '0;
    cyc(200);
    rd_chk("R10 glitch stat", 8'h10, 32'h0);
    rd_chk("R10 glitch xpos", 8'h30, ~(32'd1 << 5));

    // R9 priority
    keys[5*NC+0] = 1'b1; keys[2*NC+6] = 1'b1; keys[2*NC+1] = 1'b1;
    cyc(200);
    rd_chk("R9 xpos", 8'h30, ~(32'd1 << 1));
    rd_chk("R9 ypos", 8'h34, ~(32'd1 << 2));
    keys = '0;
    cyc(150);
    wr_reg(8'h00, C_RUN | 32'h400);

    // R11 keypad disabled
    wr_reg(8'h00, 32'h204);
    keys[7*NC+7] = 1'b1;
    cyc(200);
    rd_chk("R11 xpos", 8'h30, ~(32'd1 << 1));
    rd_chk("R11 ypos", 8'h34, ~(32'd1 << 2));
    rd_chk("R11 stat", 8'h10, 32'h0);
    keys = '0;
    cyc(150);
    wr_reg(8'h00, C_RUN);

    // random presses, R7 / R9 against the model
    for (int it = 0; it < 24; it++) begin
      int p = int'($urandom_range(0, 7));
      int scan = NR * dwell_of(p);
      int nk = int'($urandom_range(1, 3));
      int fk;
      logic [NR*NC-1:0] k = '0;
      wr_reg(8'h38, 32'(p));
      for (int j = 0; j < nk; j++) k[$urandom_range(0, NR*NC-1)] = 1'b1;
      if (it == 0) k = 64'h8000_0000_0000_0000;
      if (it == 1) k = 64'h0000_0000_0000_0001;
      fk = first_key(k);
      keys = k;
      cyc(4 * scan + 20);
      rd_chk("R7 rnd xpos", 8'h30, ~(32'd1 << (fk % NC)));
      rd_chk("R9 rnd ypos", 8'h34, ~(32'd1 << (fk / NC)));
      rd_chk("R7 rnd stat", 8'h10, 32'h4);
      keys = '0;
      cyc(3 * scan + 10);
      wr_reg(8'h00, C_RUN | 32'h400);
      rd_reg(8'h10, xv);
      chk("R4 rnd clear", xv, 32'h0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule